// File: doc/BRIEF.md
# Staged Power-Up Reset Sequencer With Lock Verification

This block brings up an external device that has three separately reset sections: a digital core, an analog front end for a parallel interface, and an analog front end for a serial interface. A one-cycle start pulse begins the sequence. The block drives the device's active-low reset pin low and keeps it low for a minimum time. It then waits for an input that reports external clocks and the reference selection as stable, and keeps reset low for a second minimum time. After reset is released, it waits for the device's internal synthesizer to settle and for the serial link to stabilize. At the end of these waits it samples the device status in a single check cycle.

The check passes only when all three of these hold: the parallel-side timer-expired flag is set, none of the parallel-side out-of-lock flags is set, and the serial-side PLL-locked flag is set. On a failed check, or when the clock-stable wait times out, the whole sequence runs again with reset low. After the allowed number of attempts the block reports failure. All durations are parameters counted in clock cycles. By default each is one millisecond longer than the minimum the device needs.

Top module: `pwrup_reset_sequencer`

## Requirements
- R1: After the synchronous reset `rst`, `dev_rst_n_o` is 1 and `done_o`, `success_o` and `attempts_o` are 0.
- R2: A `start_i` pulse seen while idle or done makes `dev_rst_n_o` 0, `done_o` 0, `success_o` 0 and `attempts_o` 1 in the next cycle.
- R3: Within an attempt, reset stays low for exactly PRE_HOLD_CYC cycles, then for the cycles spent waiting on `clk_stable_i` (at least one), then for POST_HOLD_CYC cycles. When the clocks are already stable, the low time is PRE_HOLD_CYC+1+POST_HOLD_CYC.
- R4: After release, `dev_rst_n_o` stays 1 for SETTLE_CYC+SERIAL_CYC cycles plus one check cycle before the attempt's outcome takes effect.
- R5: The check passes only if `pl_expired_i`=1, every bit of `pl_unlock_i` is 0, and `ser_locked_i`=1, all sampled in the check cycle. Any single failing condition fails the attempt.
- R6: A failed attempt with attempts remaining pulls reset low again at once, increments `attempts_o` by one, and repeats the full sequence. At most MAX_TRIES (default 3) attempts are made.
- R7: On a pass, `done_o`=1, `success_o`=1 and `dev_rst_n_o`=1. After MAX_TRIES failures, `done_o`=1, `success_o`=0, `attempts_o`=MAX_TRIES, and `dev_rst_n_o` is held at 0.
- R8: If `clk_stable_i` has not been seen by the end of CLK_TIMEOUT_CYC wait cycles, the attempt fails, so such an attempt keeps reset low for PRE_HOLD_CYC+CLK_TIMEOUT_CYC cycles. Stability seen in the last wait cycle counts as stable.
- R9: `start_i` during a running sequence is ignored: timing, attempt count and outcome are unchanged.
- R10: `done_o`, `success_o`, `attempts_o` and `dev_rst_n_o` stay constant after done until the next `start_i`, whatever the status inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new sequence (ignored while busy) |
| clk_stable_i | input | 1 | External clocks and reference selection stable |
| pl_expired_i | input | 1 | Parallel-side internal timer expired |
| pl_unlock_i | input | OOL_W | Parallel-side out-of-lock flags, all must be 0 |
| ser_locked_i | input | 1 | Serial-side PLL locked |
| dev_rst_n_o | output | 1 | Active-low device reset pin |
| done_o | output | 1 | Sequence finished |
| success_o | output | 1 | Finished with a passing check |
| attempts_o | output | TRY_W | Number of attempts begun |

## Verification
Two events can land in the same cycle. The clock-stable input can arrive in the very last cycle of the wait window, the same cycle in which the timeout would expire and fail the attempt. The bench raises `clk_stable_i` so that the design first samples it exactly in that cycle, and it requires a first-attempt pass with a low time of PRE_HOLD_CYC+CLK_TIMEOUT_CYC+POST_HOLD_CYC. A one-cycle-later case requires a timeout, an unbroken low stretch and a second attempt. A further collision is a start pulse that falls inside a running sequence: the bench requires the total cycle count to done and the attempt count to match the model exactly.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD_PRE,
    ST_WAIT_CLK,
    ST_HOLD_POST,
    ST_SETTLE,
    ST_SER_WAIT,
    ST_CHECK,
    ST_DONE
  } rsq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_interval_timer.sv
module rsq_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  assign last = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!last)     cnt <= cnt + 1'b1;
  end

  // R3: the count never runs past the limit of the current phase
  a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
    !restart |=> cnt < limit);

endmodule

// File: rtl/rsq_try_counter.sv
module rsq_try_counter #(
  parameter int MAX_TRIES = 3,
  parameter int TRY_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             bump,
  output logic [TRY_W-1:0] count,
  output logic             spent
);

  assign spent = (count >= TRY_W'(MAX_TRIES));

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (first) count <= TRY_W'(1);
    else if (bump)  count <= count + 1'b1;
  end

  a_r6_tries_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= TRY_W'(MAX_TRIES));

  a_r6_no_bump_when_spent: assert property (@(posedge clk) disable iff (rst)
    bump |-> !spent);

endmodule

// File: rtl/rsq_lock_check.sv
module rsq_lock_check #(
  parameter int OOL_W = 4
) (
  input  logic             expired,
  input  logic [OOL_W-1:0] unlock,
  input  logic             ser_locked,
  output logic             pass
);

  logic any_unlock;

  always_comb begin
    any_unlock = 1'b0;
    for (int i = 0; i < OOL_W; i++) any_unlock = any_unlock | unlock[i];
  end

  assign pass = expired & ~any_unlock & ser_locked;

endmodule

// File: rtl/pwrup_reset_sequencer.sv
module pwrup_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int PRE_HOLD_CYC    = 250000,
  parameter int CLK_TIMEOUT_CYC = 1250000,
  parameter int POST_HOLD_CYC   = 250000,
  parameter int SETTLE_CYC      = 1875000,
  parameter int SERIAL_CYC      = 150000,
  parameter int MAX_TRIES       = 3,
  parameter int OOL_W           = 4,
  localparam int TRY_W          = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             clk_stable_i,
  input  logic             pl_expired_i,
  input  logic [OOL_W-1:0] pl_unlock_i,
  input  logic             ser_locked_i,
  output logic             dev_rst_n_o,
  output logic             done_o,
  output logic             success_o,
  output logic [TRY_W-1:0] attempts_o
);

  localparam int LIM_MAX = max2(max2(max2(PRE_HOLD_CYC, CLK_TIMEOUT_CYC),
                                     max2(POST_HOLD_CYC, SETTLE_CYC)), SERIAL_CYC);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  rsq_state_e       st, nxt;
  logic [CNT_W-1:0] lim;
  logic             tmr_last, tmr_restart;
  logic             lock_ok, spent;
  logic             go, retry, attempt_fail, finish, fin_ok, rst_n_nxt;

  rsq_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(tmr_restart), .limit(lim), .last(tmr_last)
  );

  rsq_try_counter #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_tries (
    .clk(clk), .rst(rst), .first(go), .bump(retry), .count(attempts_o), .spent(spent)
  );

  rsq_lock_check #(.OOL_W(OOL_W)) u_check (
    .expired(pl_expired_i), .unlock(pl_unlock_i), .ser_locked(ser_locked_i), .pass(lock_ok)
  );

  always_comb begin
    unique case (st)
      ST_HOLD_PRE:  lim = CNT_W'(PRE_HOLD_CYC);
      ST_WAIT_CLK:  lim = CNT_W'(CLK_TIMEOUT_CYC);
      ST_HOLD_POST: lim = CNT_W'(POST_HOLD_CYC);
      ST_SETTLE:    lim = CNT_W'(SETTLE_CYC);
      ST_SER_WAIT:  lim = CNT_W'(SERIAL_CYC);
      default:      lim = CNT_W'(1);
    endcase
  end

  always_comb begin
    nxt          = st;
    go           = 1'b0;
    retry        = 1'b0;
    attempt_fail = 1'b0;
    finish       = 1'b0;
    fin_ok       = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE: if (start_i) begin nxt = ST_HOLD_PRE; go = 1'b1; end
      ST_HOLD_PRE:  if (tmr_last) nxt = ST_WAIT_CLK;
      ST_WAIT_CLK:  if (clk_stable_i) nxt = ST_HOLD_POST;
                    else if (tmr_last) attempt_fail = 1'b1;
      ST_HOLD_POST: if (tmr_last) nxt = ST_SETTLE;
      ST_SETTLE:    if (tmr_last) nxt = ST_SER_WAIT;
      ST_SER_WAIT:  if (tmr_last) nxt = ST_CHECK;
      ST_CHECK: begin
        if (lock_ok) begin nxt = ST_DONE; finish = 1'b1; fin_ok = 1'b1; end
        else attempt_fail = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
    if (attempt_fail) begin
      if (spent) begin nxt = ST_DONE; finish = 1'b1; end
      else begin nxt = ST_HOLD_PRE; retry = 1'b1; end
    end
  end

  assign tmr_restart = (nxt != st);

  always_comb begin
    unique case (nxt)
      ST_HOLD_PRE, ST_WAIT_CLK, ST_HOLD_POST: rst_n_nxt = 1'b0;
      ST_DONE: rst_n_nxt = finish ? fin_ok : dev_rst_n_o;
      default: rst_n_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      dev_rst_n_o <= 1'b1;
      done_o      <= 1'b0;
      success_o   <= 1'b0;
    end else begin
      st          <= nxt;
      dev_rst_n_o <= rst_n_nxt;
      if (go) begin
        done_o    <= 1'b0;
        success_o <= 1'b0;
      end else if (finish) begin
        done_o    <= 1'b1;
        success_o <= fin_ok;
      end
    end
  end

  a_r2_start_pulls_low: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE || st == ST_DONE) && start_i) |=>
      (!dev_rst_n_o && !done_o && attempts_o == TRY_W'(1)));

  a_r4_released_in_settle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE || st == ST_SER_WAIT || st == ST_CHECK) |-> dev_rst_n_o);

  a_r7_success_released: assert property (@(posedge clk) disable iff (rst)
    success_o |-> (done_o && dev_rst_n_o));

  a_r7_fail_holds_reset: assert property (@(posedge clk) disable iff (rst)
    (done_o && !success_o) |-> (!dev_rst_n_o && attempts_o == TRY_W'(MAX_TRIES)));

  a_r8_timeout_retries: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_CLK && !clk_stable_i && tmr_last && !spent) |=>
      (st == ST_HOLD_PRE && !dev_rst_n_o && attempts_o == $past(attempts_o) + 1'b1));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_DONE && start_i && !finish && !retry) |=>
      $stable(attempts_o));

  a_r10_results_held: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=>
      (done_o && $stable(success_o) && $stable(attempts_o) && $stable(dev_rst_n_o)));

endmodule

// File: tb/test_pwrup_reset_sequencer.sv
`timescale 1ns/1ps
module test_pwrup_reset_sequencer;

  localparam int HP  = 20;
  localparam int TO  = 30;
  localparam int HPO = 15;
  localparam int SET = 40;
  localparam int SER = 10;
  localparam int MT  = 3;
  localparam int NEVER = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic       start, stable, expired, pll;
  logic [3:0] ool;
  logic       rst_n, done, succ;
  logic [1:0] att;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwrup_reset_sequencer #(
    .PRE_HOLD_CYC(HP), .CLK_TIMEOUT_CYC(TO), .POST_HOLD_CYC(HPO),
    .SETTLE_CYC(SET), .SERIAL_CYC(SER), .MAX_TRIES(MT), .OOL_W(4)
  ) i_pwrup_reset_sequencer (
    .clk(clk), .rst(rst), .start_i(start), .clk_stable_i(stable),
    .pl_expired_i(expired), .pl_unlock_i(ool), .ser_locked_i(pll),
    .dev_rst_n_o(rst_n), .done_o(done), .success_o(succ), .attempts_o(att)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_status(input bit good, input int badsel);
    expired = 1'b1; ool = 4'b0000; pll = 1'b1;
    if (!good) begin
      case (badsel)
        0:       expired = 1'b0;
        1:       ool     = 4'b0100;
        default: pll     = 1'b0;
      endcase
    end
  endtask

  // Model from the requirements: total cycles to done, attempts, success,
  // first low stretch and first high stretch.
  task automatic model(input int js, input int good_from,
                       output int total, output int n, output int ok,
                       output int low1, output int high1);
    int pt, lr, h, pa;
    pt = HP + TO;
    lr = HP + 1 + HPO;
    h  = SET + SER + 1;
    if (js > pt && js >= NEVER) begin
      total = 3 * pt; n = 3; ok = 0; low1 = 3 * pt; high1 = 0;
    end else if (js > pt) begin
      pa = (good_from < 2) ? 2 : good_from;
      ok = (pa <= MT);
      n  = ok ? pa : MT;
      total = pt + (n - 1) * (lr + h);
      low1 = pt + lr; high1 = h;
    end else begin
      ok = (good_from <= MT);
      n  = ok ? good_from : MT;
      low1 = HP + ((js > HP + 1) ? js - HP : 1) + HPO;
      total = low1 + h + (n - 1) * (lr + h);
      high1 = h;
    end
  endtask

  task automatic run_case(input string tag, input int js, input int good_from,
                          input int badsel, input bit poke);
    int total_e, n_e, ok_e, low_e, high_e;
    int n, low1, high1, phase;
    bit hung;
    model(js, good_from, total_e, n_e, ok_e, low_e, high_e);
    @(negedge clk);
    stable = (js == 0);
    set_status(good_from <= 0, badsel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1; low1 = 0; high1 = 0; phase = 0; hung = 1'b0;
    chk({tag, " R2 rst_n low after start"}, int'(rst_n), 0);
    chk({tag, " R2 attempts after start"}, int'(att), 1);
    chk({tag, " R2 done cleared"}, int'(done), 0);
    while (!done) begin
      if (n >= js) stable = 1'b1;
      set_status(int'(att) >= good_from, badsel);
      start = (poke && n == 5);
      if (phase == 0) begin
        if (!rst_n) low1++; else begin phase = 1; high1 = 1; end
      end else if (phase == 1) begin
        if (rst_n) high1++; else phase = 2;
      end
      @(negedge clk);
      n++;
      if (n > 5000) begin hung = 1'b1; break; end
    end
    start = 1'b0;
    if (hung) begin
      checks++; errors++;
      $display("FAIL %s watchdog: actual %0d expected %0d", tag, n, total_e);
    end
    chk({tag, " R6 cycles to done (R9 when poked)"}, n - 1, total_e);
    chk({tag, " R7 success"}, int'(succ), ok_e);
    chk({tag, " R6 attempts"}, int'(att), n_e);
    chk({tag, " R7 rst_n at done"}, int'(rst_n), ok_e);
    chk({tag, " R3/R8 first low stretch"}, low1, low_e);
    chk({tag, " R4 first high stretch"}, high1, high_e);
    for (int k = 0; k < 6; k++) begin
      stable = ~stable;
      set_status(k[0], k % 3);
      @(negedge clk);
      chk({tag, " R10 done held"}, int'(done), 1);
      chk({tag, " R10 success held"}, int'(succ), ok_e);
      chk({tag, " R10 attempts held"}, int'(att), n_e);
      chk({tag, " R10 rst_n held"}, int'(rst_n), ok_e);
    end
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0019;
    void'($urandom(seed));
    rst = 1'b1; start = 1'b0; stable = 1'b0;
    expired = 1'b0; ool = 4'b0; pll = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rst_n after reset", int'(rst_n), 1);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 success after reset", int'(succ), 0);
    chk("R1 attempts after reset", int'(att), 0);

    run_case("R3 stable early", 0, 1, 0, 1'b0);
    run_case("R8 stable at last wait cycle", HP + TO, 1, 0, 1'b0);
    run_case("R8 stable one cycle late", HP + TO + 1, 1, 1, 1'b0);
    run_case("R8 never stable", NEVER, 1, 0, 1'b0);
    run_case("R5 expired low", 0, 4, 0, 1'b0);
    run_case("R5 unlock flag", 0, 4, 1, 1'b0);
    run_case("R5 pll low", 0, 4, 2, 1'b0);
    run_case("R6 pass on second", 5, 2, 1, 1'b0);
    run_case("R6 pass on third", HP + 3, 3, 2, 1'b0);
    run_case("R9 start while busy", HP + 7, 2, 0, 1'b1);

    for (int i = 0; i < 24; i++) begin
      run_case("rand", int'($urandom_range(HP + TO, 0)), int'($urandom_range(4, 1)),
               int'($urandom_range(2, 0)), 1'($urandom_range(1, 0)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule